// File: doc/BRIEF.md
# Soft-Ramp Digital Volume Attenuator

This block scales a stereo pair of signed audio samples by a gain taken from an 8-bit attenuation code. It does not jump to a newly written code. It keeps an internal current code and moves it one count at a time, on sample strobes, toward the goal. The pace is set so that a full-span move of 255 counts completes in a selectable number of sample periods. The long setting is the default and gives 1061 periods. The short setting gives 256 periods.

A path-enable input sets the goal. While the path is disabled the goal is mute, so disabling ramps the level down and enabling ramps it back up to the programmed code. Gain is linear in the code. Code 00h is a hard mute, and code FFh passes samples unchanged. A new goal written during a ramp redirects the ramp from wherever the current code stands. The ramp-done flag reports when the current code has reached the goal.

Top module: `soft_vol_ramp`

## Requirements
- R1: While reset is held and after it is released, out_valid, out_left and out_right are 0 and ramp_done is 1 (the current code resets to 00h and path_en is low).
- R2: At current code FFh the output equals the input sample exactly, including the extreme values -32768 and 32767.
- R3: For current codes 01h..FEh the output is (sample*code + 128) >> 8, using an arithmetic shift, saturated to 16 bits.
- R4: At current code 00h the output is exactly 0 for any input sample.
- R5: With fast_sel=1, a move from 00h to FFh is not finished after 255 strobes and is finished after 256 strobes.
- R6: With fast_sel=0, a move from 00h to FFh is not finished after 1060 strobes and is finished after 1061 strobes.
- R7: The current code changes by at most one count per clock.
- R8: A goal changed during a ramp redirects the ramp from the present code with no jump, and the code never passes the goal.
- R9: Taking path_en low ramps the code down to 00h, giving zero output. Taking path_en high ramps the code up to target_code.
- R10: ramp_done is 0 whenever the current code differs from the goal, including the cycle right after a new goal is presented.
- R11: Without a sample strobe the current code does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | One-cycle sample strobe at the sample rate |
| smp_left | input | 16 | Left input sample, signed |
| smp_right | input | 16 | Right input sample, signed |
| target_code | input | 8 | Programmed attenuation code (00h mute, FFh unity) |
| fast_sel | input | 1 | 0: 1061-period ramp, 1: 256-period ramp |
| path_en | input | 1 | 1: goal is target_code, 0: goal is mute |
| out_valid | output | 1 | Strobe for the scaled output pair |
| out_left | output | 16 | Scaled left sample |
| out_right | output | 16 | Scaled right sample |
| ramp_done | output | 1 | High when the current code equals the goal |

## Verification
Scaled samples appear one clock after their strobe. They are scaled by the code as it stood before that strobe's ramp step. The step taken on a strobe is therefore visible only in the next strobe's output. ramp_done is combinational from the registered code and the goal, so it drops in the same cycle a new goal is presented. It rises one clock after the strobe that completes the move. The bench drives every strobe on a falling edge and reads all outputs on the following falling edge, once both updates have settled. Ramp length is counted in strobes and never in clocks, which also lets long idle gaps between strobes test that the code holds.

// File: rtl/svr_pkg.sv
package svr_pkg;
  localparam int CODE_W = 8;
  localparam int COEF_W = CODE_W + 1;
  localparam int FRAC_W = 8;
  localparam int SPAN   = (1 << CODE_W) - 1;

  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } ramp_dir_e;

  // Linear gain in units of 1/256; the top code maps to exactly unity.
  function automatic logic [COEF_W-1:0] gain_coef(input logic [CODE_W-1:0] code);
    if (code == '1) return COEF_W'(1) << FRAC_W;
    return {1'b0, code};
  endfunction
endpackage

// File: rtl/ramp_ctrl.sv
module ramp_ctrl
  import svr_pkg::*;
#(
  parameter int LONG_STEPS  = 1061,
  parameter int SHORT_STEPS = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              fast_sel,
  input  logic              path_en,
  input  logic [CODE_W-1:0] target_code,
  output logic [CODE_W-1:0] cur_code,
  output logic              ramp_done
);
  localparam int MAXN  = (LONG_STEPS > SHORT_STEPS) ? LONG_STEPS : SHORT_STEPS;
  localparam int ACC_W = $clog2(MAXN + SPAN + 1);

  logic [ACC_W-1:0]  acc, acc_sum, acc_rem, period;
  logic [CODE_W-1:0] goal;
  ramp_dir_e         dir;
  logic              step_due;

  assign goal     = path_en ? target_code : '0;
  assign period   = fast_sel ? ACC_W'(SHORT_STEPS) : ACC_W'(LONG_STEPS);
  assign acc_sum  = acc + ACC_W'(SPAN);
  assign acc_rem  = acc_sum - period;
  assign step_due = strobe && (dir != DIR_HOLD) && (acc_sum >= period);
  assign ramp_done = (dir == DIR_HOLD);

  always_comb begin
    if (cur_code < goal)      dir = DIR_UP;
    else if (cur_code > goal) dir = DIR_DOWN;
    else                      dir = DIR_HOLD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_code <= '0;
      acc      <= '0;
    end else if (dir == DIR_HOLD) begin
      acc <= '0;
    end else if (strobe) begin
      if (step_due) begin
        acc      <= (acc_rem >= period) ? '0 : acc_rem;
        cur_code <= (dir == DIR_UP) ? cur_code + 1'b1 : cur_code - 1'b1;
      end else begin
        acc <= acc_sum;
      end
    end
  end

  assert_step_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cur_code == $past(cur_code)) || (cur_code == $past(cur_code) + 1'b1)
             || (cur_code == $past(cur_code) - 1'b1));

  assert_hold_no_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(cur_code));

  assert_no_overshoot_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dir == DIR_UP) |=> cur_code <= $past(goal));

  assert_no_overshoot_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dir == DIR_DOWN) |=> cur_code >= $past(goal));

  always_comb begin
    if (rst_n) assert_acc_range_R5: assert (acc < ACC_W'(MAXN));
  end
endmodule

// File: rtl/gain_mult.sv
module gain_mult
  import svr_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       valid,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic [CODE_W-1:0]          code,
  output logic signed [SAMPLE_W-1:0] out_sample
);
  localparam int PROD_W = SAMPLE_W + COEF_W + 1;
  localparam logic signed [PROD_W-1:0] MAXV = PROD_W'((64'sd1 <<< (SAMPLE_W - 1)) - 1);
  localparam logic signed [PROD_W-1:0] MINV = -MAXV - 1;

  function automatic logic signed [SAMPLE_W-1:0] scale_sat(
    input logic signed [SAMPLE_W-1:0] s, input logic [CODE_W-1:0] c);
    logic signed [PROD_W-1:0] prod, rnd, sh;
    if (c == '0) return '0;
    prod = PROD_W'(s) * PROD_W'($signed({1'b0, gain_coef(c)}));
    rnd  = prod + (PROD_W'(1) <<< (FRAC_W - 1));
    sh   = rnd >>> FRAC_W;
    if (sh > MAXV) return SAMPLE_W'(MAXV);
    if (sh < MINV) return SAMPLE_W'(MINV);
    return SAMPLE_W'(sh);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     out_sample <= '0;
    else if (valid) out_sample <= scale_sat(sample, code);
  end

  assert_mute_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && code == '0) |=> out_sample == '0);

  assert_unity_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && code == '1) |=> out_sample == $past(sample));
endmodule

// File: rtl/soft_vol_ramp.sv
module soft_vol_ramp
  import svr_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int LONG_STEPS  = 1061,
  parameter int SHORT_STEPS = 256
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       smp_valid,
  input  logic signed [SAMPLE_W-1:0] smp_left,
  input  logic signed [SAMPLE_W-1:0] smp_right,
  input  logic [CODE_W-1:0]          target_code,
  input  logic                       fast_sel,
  input  logic                       path_en,
  output logic                       out_valid,
  output logic signed [SAMPLE_W-1:0] out_left,
  output logic signed [SAMPLE_W-1:0] out_right,
  output logic                       ramp_done
);
  localparam int NCH = 2;

  logic [CODE_W-1:0]          cur_code;
  logic signed [SAMPLE_W-1:0] ch_in  [NCH];
  logic signed [SAMPLE_W-1:0] ch_out [NCH];

  assign ch_in[0]  = smp_left;
  assign ch_in[1]  = smp_right;
  assign out_left  = ch_out[0];
  assign out_right = ch_out[1];

  ramp_ctrl #(.LONG_STEPS(LONG_STEPS), .SHORT_STEPS(SHORT_STEPS)) u_ramp (
    .clk(clk), .rst_n(rst_n), .strobe(smp_valid), .fast_sel(fast_sel),
    .path_en(path_en), .target_code(target_code),
    .cur_code(cur_code), .ramp_done(ramp_done)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    gain_mult #(.SAMPLE_W(SAMPLE_W)) u_mult (
      .clk(clk), .rst_n(rst_n), .valid(smp_valid),
      .sample(ch_in[g]), .code(cur_code), .out_sample(ch_out[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= smp_valid;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (out_valid == 1'b0 && out_left == '0 && out_right == '0));
endmodule

// File: tb/soft_vol_ramp_bench.sv
module soft_vol_ramp_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic signed [15:0] smp_left = '0, smp_right = '0;
  logic [7:0] target_code = '0;
  logic fast_sel = 1'b0, path_en = 1'b0;
  logic out_valid, ramp_done;
  logic signed [15:0] out_left, out_right;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  soft_vol_ramp u_soft_vol_ramp (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_left(smp_left),
    .smp_right(smp_right), .target_code(target_code), .fast_sel(fast_sel),
    .path_en(path_en), .out_valid(out_valid), .out_left(out_left),
    .out_right(out_right), .ramp_done(ramp_done)
  );

  // {sample, code, expected}
  localparam logic [39:0] VEC [9] = '{
    {16'd1000,  8'd255, 16'd1000},   // R2
    {16'h7FFF,  8'd255, 16'h7FFF},   // R2
    {16'h8000,  8'd255, 16'h8000},   // R2
    {16'd1000,  8'd128, 16'd500},    // R3
    {16'hFC18,  8'd128, 16'hFE0C},   // R3
    {16'd200,   8'd1,   16'd1},      // R3
    {16'd3,     8'd1,   16'd0},      // R3
    {16'hFFF9,  8'd64,  16'hFFFE},   // R3
    {16'd100,   8'd0,   16'd0}       // R4
  };

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe(input logic signed [15:0] s);
    @(negedge clk);
    smp_valid = 1'b1; smp_left = s; smp_right = s;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) strobe(16'sd256);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int jumps;
    int prev;
    repeat (4) @(negedge clk);
    check("R1 out_valid", out_valid, 0);
    check("R1 out_left", out_left, 0);
    check("R1 ramp_done", ramp_done, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_right after release", out_right, 0);

    // Long ramp 00h -> FFh
    path_en = 1'b1; target_code = 8'hFF; fast_sel = 1'b0;
    #1;
    check("R10 done drops on new goal", ramp_done, 0);
    repeat (50) @(negedge clk);
    check("R11 no strobe keeps ramp pending", ramp_done, 0);
    strobe(16'sd256);
    check("R11 code held at mute, R4 zero out", out_left, 0);
    strobes(1059);
    check("R6 not done after 1060", ramp_done, 0);
    strobes(1);
    check("R6 done after 1061", ramp_done, 1);
    strobe(16'sd256);
    check("R6 unity after ramp", out_left, 256);

    // Short ramp down via path disable
    fast_sel = 1'b1; path_en = 1'b0;
    strobes(255);
    check("R5 not done after 255", ramp_done, 0);
    strobes(1);
    check("R5 done after 256", ramp_done, 1);
    strobe(16'sd1000);
    check("R9 disabled path is muted", out_left, 0);
    path_en = 1'b1;
    strobes(256);
    check("R9 re-enable reaches goal", ramp_done, 1);
    strobe(16'sd1000);
    check("R9 re-enable level", out_right, 1000);

    // Static gain table
    foreach (VEC[i]) begin
      target_code = VEC[i][23:16];
      strobes(300);
      strobe(VEC[i][39:24]);
      check("R2/R3/R4 left", out_left, longint'($signed(VEC[i][15:0])));
      check("R2/R3/R4 right", out_right, longint'($signed(VEC[i][15:0])));
    end

    // Redirect mid-ramp
    target_code = 8'd200; strobes(300);
    target_code = 8'd250; strobes(30);
    check("R8 mid-ramp pending", ramp_done, 0);
    strobe(16'sd256);
    prev = int'(out_left);
    target_code = 8'd100;
    jumps = 0;
    for (int i = 0; i < 260; i++) begin
      strobe(16'sd256);
      if (int'(out_left) - prev > 1 || prev - int'(out_left) > 1) jumps++;
      prev = int'(out_left);
    end
    check("R8 no jump on redirect", jumps, 0);
    check("R8 settles on new goal", out_left, 100);
    check("R7 done after redirect", ramp_done, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule